// File: doc/BRIEF.md
# Grouped Change-of-State Input Port

This block presents 48 digital input lines to a host through an eight-address, byte-wide register window. The host reads the current level of every line, eight lines per byte, and can ask to be told when a level moves. Lines are watched in six groups of eight. A rise or a fall on any line of a group counts as a change for that group. The lines cannot be driven, and there is no direction setting.

Address 7 serves two purposes. A write to it loads a six-bit mask that chooses which groups may raise an interrupt. A read from it returns a pending flag for each group whose change was caught while enabled. Bit 6 of the same byte is an active-low copy of the interrupt line. The read also acknowledges: all pending flags clear and the interrupt drops on the same clock edge. The one exception is a change that arrives on that same edge, which stays pending.

Interrupt sequencing is a two-state machine. In `ST_QUIET` the interrupt is low. Transition T_ARM moves it to `ST_PENDING` when an enabled group changes. In `ST_PENDING` the interrupt is high. Transition T_ACK returns it to `ST_QUIET` on a status read that coincides with no enabled change. Transition T_REARM keeps it in `ST_PENDING` when an enabled change lands in the same cycle as the status read. In every other case, including `ST_QUIET` with no enabled change, the state holds.

Top module: `cos_input_ctrl`

## Requirements
- R1: A read of address 0, 1, 2, 4, 5 or 6 returns the level of group 0, 1, 2, 3, 4 or 5 respectively, with bit n holding line 8*group+n. A change on `line_in` appears in `bus_rdata` after two rising edges of `clk`, which is the two-flop synchroniser.
- R2: A read of address 3 returns 0x00.
- R3: After reset the enable mask is 0, no flag is pending and `irq_o` is low. A write to address 7 loads `bus_wdata[5:0]` as the enable mask, where bit k enables group k.
- R4: A write to any address other than 7 has no effect. Enabled groups, pending flags and line levels stay as they were.
- R5: A rising or a falling change on any line of an enabled group k sets pending bit k. `irq_o` goes high on the third rising edge after the line changes.
- R6: A change in a group whose enable bit is 0 sets no pending flag and does not raise `irq_o`.
- R7: A read of address 7 returns the pending flags in bits 5:0. Bit 6 is 0 while `irq_o` is high and 1 while it is low. Bit 7 is 0.
- R8: A read of address 7 clears all pending flags and lowers `irq_o` at the clock edge that ends the read.
- R9: An enabled change detected in the same cycle as a read of address 7 stays pending after the read. `irq_o` stays high (T_REARM).
- R10: `irq_o` is high exactly when at least one pending flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 48 | Asynchronous digital input lines |
| bus_addr | input | 3 | Register address within the window |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while `bus_rd` is high |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
On every cycle, the assertions check four things:
- the mask load on a write to address 7, and its stability under any other write;
- that no pending flag appears without an enabled change;
- the acknowledge-and-keep behaviour of a status read;
- that the interrupt agrees with the pending flags and with bit 6 of the status byte.

Only the bench scenarios can show the rest. These are the synchroniser latency seen at the ports, the address-to-group mapping of the level reads, and both edge directions raising a flag. The bench also shows that a change on a disabled group, or after writes to other addresses, leaves the interrupt low.

// File: rtl/cos_pkg.sv
package cos_pkg;
    typedef enum logic [0:0] {
        ST_QUIET   = 1'b0,
        ST_PENDING = 1'b1
    } cos_state_e;

    localparam logic [2:0] STATUS_OFS = 3'd7;
    localparam int         IRQ_N_BIT  = 6;

    // Level bytes skip address 3: groups 0..2 sit at 0..2, groups 3..5 at 4..6.
    function automatic logic [2:0] grp_ofs(input int g);
        return (g < 3) ? 3'(g) : 3'(g + 1);
    endfunction
endpackage

// File: rtl/cos_sync.sv
module cos_sync #(
    parameter int WIDTH  = 48,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q_out
);
    logic [WIDTH-1:0] stg_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stg_q[s] <= '0;
                end else begin
                    stg_q[s] <= (s == 0) ? d_in : stg_q[(s == 0) ? 0 : s - 1];
                end
            end
        end
    endgenerate

    assign q_out = stg_q[STAGES-1];
endmodule

// File: rtl/cos_change_det.sv
module cos_change_det #(
    parameter int GROUP_W = 8,
    parameter int NUM_GRP = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_GRP*GROUP_W-1:0] lvl,
    output logic [NUM_GRP-1:0]         chg_grp
);
    localparam int LINES = NUM_GRP * GROUP_W;

    logic [LINES-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl;
    end

    generate
        for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
            assign chg_grp[g] = |(lvl[g*GROUP_W +: GROUP_W] ^ prev_q[g*GROUP_W +: GROUP_W]);
        end
    endgenerate
endmodule

// File: rtl/cos_rd_mux.sv
module cos_rd_mux
    import cos_pkg::*;
#(
    parameter int GROUP_W = 8,
    parameter int NUM_GRP = 6
) (
    input  logic [NUM_GRP*GROUP_W-1:0] lvl,
    input  logic [NUM_GRP-1:0]         pend,
    input  logic                       irq,
    input  logic [2:0]                 addr,
    input  logic                       rd,
    output logic [7:0]                 rdata
);
    always_comb begin
        rdata = '0;
        if (rd) begin
            if (addr == STATUS_OFS) begin
                rdata[NUM_GRP-1:0] = pend;
                rdata[IRQ_N_BIT]   = ~irq;
            end else begin
                for (int g = 0; g < NUM_GRP; g++) begin
                    if (addr == grp_ofs(g)) rdata[GROUP_W-1:0] = lvl[g*GROUP_W +: GROUP_W];
                end
            end
        end
    end
endmodule

// File: rtl/cos_input_ctrl.sv
module cos_input_ctrl
    import cos_pkg::*;
#(
    parameter int GROUP_W     = 8,
    parameter int NUM_GRP     = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_GRP*GROUP_W-1:0] line_in,
    input  logic [2:0]                 bus_addr,
    input  logic                       bus_rd,
    input  logic                       bus_wr,
    input  logic [7:0]                 bus_wdata,
    output logic [7:0]                 bus_rdata,
    output logic                       irq_o
);
    localparam int LINES = NUM_GRP * GROUP_W;

    logic [LINES-1:0]   lvl_s;
    logic [NUM_GRP-1:0] chg_grp;
    logic [NUM_GRP-1:0] en_q;
    logic [NUM_GRP-1:0] pend_q, pend_d;
    logic               status_rd, cfg_wr, hit_any;
    cos_state_e         state_q, state_d;
    logic [7-NUM_GRP:0] unused_wdata_hi;

    assign unused_wdata_hi = bus_wdata[7:NUM_GRP];

    cos_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .d_in(line_in), .q_out(lvl_s)
    );

    cos_change_det #(.GROUP_W(GROUP_W), .NUM_GRP(NUM_GRP)) det_i (
        .clk(clk), .rst_n(rst_n), .lvl(lvl_s), .chg_grp(chg_grp)
    );

    assign status_rd = bus_rd && (bus_addr == STATUS_OFS);
    assign cfg_wr    = bus_wr && (bus_addr == STATUS_OFS);
    assign hit_any   = |(chg_grp & en_q);

    // Enable mask: loaded only by a write to the status address.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      en_q <= '0;
        else if (cfg_wr) en_q <= bus_wdata[NUM_GRP-1:0];
    end

    // Pending flags: acknowledge clears, a same-cycle enabled change survives.
    always_comb begin
        pend_d = status_rd ? '0 : pend_q;
        pend_d = pend_d | (chg_grp & en_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_QUIET;
        else        state_q <= state_d;
    end

    // Next state: T_ARM, T_ACK, T_REARM
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET: begin
                if (hit_any) state_d = ST_PENDING;          // T_ARM
            end
            ST_PENDING: begin
                if (status_rd && !hit_any) state_d = ST_QUIET; // T_ACK
                else                       state_d = ST_PENDING; // T_REARM / hold
            end
            default: state_d = ST_QUIET;
        endcase
    end

    // Outputs
    always_comb begin
        irq_o = (state_q == ST_PENDING);
    end

    cos_rd_mux #(.GROUP_W(GROUP_W), .NUM_GRP(NUM_GRP)) mux_i (
        .lvl(lvl_s), .pend(pend_q), .irq(irq_o),
        .addr(bus_addr), .rd(bus_rd), .rdata(bus_rdata)
    );
endmodule

// File: rtl/cos_input_ctrl_chk.sv
module cos_input_ctrl_chk #(
    parameter int NUM_GRP = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic [2:0]         bus_addr,
    input logic               bus_rd,
    input logic               bus_wr,
    input logic [7:0]         bus_wdata,
    input logic [7:0]         bus_rdata,
    input logic               irq_o,
    input logic [NUM_GRP-1:0] en_q,
    input logic [NUM_GRP-1:0] pend_q,
    input logic [NUM_GRP-1:0] chg_grp
);
    p_en_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd7) |=> (en_q == $past(bus_wdata[NUM_GRP-1:0])));

    p_wr_other_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!(bus_wr && bus_addr == 3'd7)) |=> $stable(en_q));

    p_no_flag_without_enabled_change_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(chg_grp & en_q)) == '0));

    p_status_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 3'd7) |-> (bus_rdata[6] == !irq_o && bus_rdata[7] == 1'b0
                                           && bus_rdata[NUM_GRP-1:0] == pend_q));

    p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 3'd7 && (chg_grp & en_q) == '0) |=> (pend_q == '0 && !irq_o));

    p_keep_same_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 3'd7 && (chg_grp & en_q) != '0)
            |=> (pend_q == $past(chg_grp & en_q) && irq_o));

    p_irq_matches_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (pend_q != '0));

    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 3'd3) |-> (bus_rdata == 8'h00));
endmodule

bind cos_input_ctrl cos_input_ctrl_chk #(.NUM_GRP(NUM_GRP)) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .en_q(en_q), .pend_q(pend_q), .chg_grp(chg_grp)
);

// File: tb/cos_input_ctrl_tb_top.sv
`timescale 1ns/1ps
module cos_input_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [47:0] line_in;
    logic [2:0]  bus_addr;
    logic        bus_rd, bus_wr;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    cos_input_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .bus_addr(bus_addr),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] addr_of(input int g);
        return (g < 3) ? 3'(g) : 3'(g + 1);
    endfunction

    function automatic logic [5:0] changed_groups(input logic [47:0] a, input logic [47:0] b);
        logic [5:0] r;
        for (int g = 0; g < 6; g++) r[g] = |(a[g*8 +: 8] ^ b[g*8 +: 8]);
        return r;
    endfunction

    function automatic logic [7:0] status_of(input logic [5:0] pend);
        return {1'b0, (pend == 6'd0), pend};
    endfunction

    // Each access starts at a falling edge and spans one rising edge.
    task automatic do_read(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic do_write(input logic [2:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0]  d;
        logic [47:0] nv;
        logic [5:0]  en, exp;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; line_in = '0; bus_addr = '0; bus_rd = 0; bus_wr = 0; bus_wdata = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        chk("R3 irq after reset", irq_o, 0);
        do_read(3'd7, d); chk("R3 R7 status after reset", d, 8'h40);
        do_read(3'd3, d); chk("R2 reserved address", d, 8'h00);
        do_read(3'd5, d); chk("R1 level after reset", d, 8'h00);

        // Rising edge on group 0, line 3
        do_write(3'd7, 8'h01);
        line_in[3] = 1'b1;
        @(negedge clk);
        do_read(3'd0, d); chk("R1 level before sync latency", d, 8'h00);
        chk("R5 irq not yet high", irq_o, 0);
        do_read(3'd0, d); chk("R1 level after two edges", d, 8'h08);
        chk("R5 irq on third edge rising", irq_o, 1);
        do_read(3'd7, d); chk("R7 status with pending", d, 8'h01);
        chk("R8 irq cleared by read", irq_o, 0);
        do_read(3'd7, d); chk("R8 R10 status after ack", d, 8'h40);

        // Falling edge
        line_in[3] = 1'b0;
        repeat (3) @(negedge clk);
        chk("R5 irq falling edge", irq_o, 1);
        do_read(3'd7, d); chk("R5 status falling edge", d, 8'h01);

        // Disabled group
        line_in[12] = 1'b1;
        repeat (4) @(negedge clk);
        chk("R6 irq disabled group", irq_o, 0);
        do_read(3'd7, d); chk("R6 status disabled group", d, 8'h40);
        do_read(3'd1, d); chk("R1 level group 1", d, 8'h10);

        // Writes to other addresses
        for (int a = 0; a < 7; a++) do_write(3'(a), 8'h3F);
        line_in[17] = 1'b1;
        repeat (4) @(negedge clk);
        chk("R4 irq after other writes", irq_o, 0);
        do_read(3'd7, d); chk("R4 status after other writes", d, 8'h40);
        do_read(3'd2, d); chk("R4 R1 level group 2", d, 8'h02);

        // Same-cycle change and acknowledge
        do_write(3'd7, 8'h3F);
        line_in[0] = 1'b1;
        repeat (3) @(negedge clk);
        chk("R5 irq group 0", irq_o, 1);
        line_in[33] = 1'b1;
        repeat (2) @(negedge clk);
        do_read(3'd7, d); chk("R9 status at same-cycle read", d, 8'h01);
        chk("R9 irq kept high", irq_o, 1);
        do_read(3'd7, d); chk("R9 kept group 4", d, 8'h10);
        chk("R10 irq low after ack", irq_o, 0);

        // Two groups together
        line_in[15] = 1'b1; line_in[47] = 1'b1;
        repeat (3) @(negedge clk);
        do_read(3'd7, d); chk("R5 two groups", d, 8'h22);

        // Random
        for (int it = 0; it < 40; it++) begin
            en = 6'($urandom);
            do_write(3'd7, {2'b00, en});
            nv  = {16'($urandom), 32'($urandom)};
            exp = changed_groups(line_in, nv) & en;
            line_in = nv;
            repeat (3) @(negedge clk);
            chk("R10 random irq", irq_o, (exp != 6'd0));
            do_read(3'd7, d); chk("R7 random status", d, status_of(exp));
            begin
                int g;
                g = int'($urandom_range(5, 0));
                do_read(addr_of(g), d); chk("R1 random level", d, nv[g*8 +: 8]);
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule